// File: doc/BRIEF.md
# Thread-Block Admission Controller

This block decides whether one more thread block may become resident on a single multiprocessor. It keeps four usage counters: resident blocks, thread slots, register-file entries and shared-memory bytes. A launch request carries the block's thread count, its registers per thread and its shared-memory bytes. The request is granted in the same cycle when every one of the four pools can absorb the cost. When the block finishes, a completion pulse with the same three parameters returns the resources.

Thread slots and registers are charged per whole warp of 32 threads, so a partly filled last warp costs as much as a full one. Malformed requests are flagged as errors instead of being left pending. A 2-bit configuration register selects how much of the 64 KB on-chip array is used as shared memory. The block also reports the resident warp count and an occupancy ratio, for use by a scheduler or a performance monitor.

Top module: `blk_admit_ctrl`

## Requirements
- R1: A request of T threads costs ceil(T/32) warps. The block charges ceil(T/32)*32 thread slots, and `warps_o` rises by ceil(T/32). For example, 161 threads cost 6 warps.
- R2: No more than 16 blocks are resident at once. A request that would make the 17th is denied.
- R3: No more than 2048 thread slots (64 warps) are in use at once. A request that would exceed this is denied.
- R4: A request costs warps*regs_per_thread*32 register entries. A request is granted only if the total in use stays at or below 65536 after the grant.
- R5: Shared-memory bytes in use after a grant never exceed the configured capacity. `cfg_split_i` is loaded when `cfg_we_i` is high and takes effect from the next cycle. Code 0 selects 16384 bytes, code 1 selects 32768, and codes 2 and 3 select 49152. Code 2 is the value after reset.
- R6: A valid request with 0 threads, more than 1024 threads or more than 255 registers per thread raises `req_error_o`. Such a request is never granted and changes no counter.
- R7: `req_grant_o` is combinational on the request and the current usage. The counters take the cost on the same rising edge, so `warps_o` shows the new count in the following cycle.
- R8: A completion returns the cost it names. When a completion and a request arrive in the same cycle, both are applied. The fit check uses the usage from before that cycle's completion.
- R9: `occupancy_o` equals warps*128/64. This is the fraction of the 64-warp maximum in unsigned Q1.7, so 128 means full.
- R10: After reset, all four counters are zero, so `warps_o` and `occupancy_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Load the shared-memory split code |
| cfg_split_i | input | 2 | Shared-memory split code |
| req_valid_i | input | 1 | Launch request present |
| req_threads_i | input | 11 | Threads in the requesting block |
| req_regs_i | input | 9 | Registers per thread of the request |
| req_shmem_i | input | 17 | Shared-memory bytes of the request |
| req_grant_o | output | 1 | Request admitted this cycle |
| req_error_o | output | 1 | Request malformed |
| rel_valid_i | input | 1 | Block completion present |
| rel_threads_i | input | 11 | Threads of the completing block |
| rel_regs_i | input | 9 | Registers per thread of the completing block |
| rel_shmem_i | input | 17 | Shared-memory bytes of the completing block |
| warps_o | output | 7 | Resident warp count |
| occupancy_o | output | 8 | Occupancy ratio, Q1.7 |

## Verification
The hardest situation to reach is a completion and a request in the same cycle while a pool is full. The stimulus first fills the thread pool to 64 warps with two 1024-thread blocks. It then offers a small request in the same cycle as a completion, and that request must still be denied. Next it offers a 512-thread request alongside another completion, and both must be applied. Each pool is also driven exactly to its limit and then probed with a one-unit request. The shared-memory pool is probed again after the split has been reduced.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

    localparam int CW        = 20;
    localparam int NUM_POOLS = 4;

    typedef enum logic [1:0] {
        POOL_BLK = 2'd0,
        POOL_THR = 2'd1,
        POOL_REG = 2'd2,
        POOL_SHM = 2'd3
    } pool_e;

    typedef logic [CW-1:0]                cnt_t;
    typedef logic [NUM_POOLS-1:0][CW-1:0] cost_vec_t;

endpackage

// File: rtl/blk_admit_cost.sv
module blk_admit_cost
    import blk_admit_pkg::*;
#(
    parameter int WARP_LANES        = 32,
    parameter int MAX_REGS          = 255,
    parameter int MAX_BLOCK_THREADS = 1024,
    parameter int TW                = 11,
    parameter int RW                = 9,
    parameter int SW                = 17
) (
    input  logic [TW-1:0] threads_i,
    input  logic [RW-1:0] regs_i,
    input  logic [SW-1:0] shmem_i,
    output cost_vec_t     cost_o,
    output logic          bad_o
);

    localparam int LANE_SHIFT = $clog2(WARP_LANES);

    cnt_t warps_w;

    // round the thread count up to whole warps
    assign warps_w = (CW'(threads_i) + CW'(WARP_LANES - 1)) >> LANE_SHIFT;

    always_comb begin
        cost_o           = '0;
        cost_o[POOL_BLK] = CW'(1);
        cost_o[POOL_THR] = warps_w << LANE_SHIFT;
        cost_o[POOL_REG] = (warps_w * CW'(regs_i)) << LANE_SHIFT;
        cost_o[POOL_SHM] = CW'(shmem_i);
    end

    assign bad_o = (threads_i == '0)
                || (threads_i > TW'(MAX_BLOCK_THREADS))
                || (regs_i > RW'(MAX_REGS));

endmodule

// File: rtl/blk_admit_pool.sv
module blk_admit_pool
    import blk_admit_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  cnt_t limit_i,
    input  logic add_en_i,
    input  cnt_t add_i,
    input  logic sub_en_i,
    input  cnt_t sub_i,
    output logic fits_o,
    output cnt_t used_o
);

    cnt_t used_q;
    cnt_t add_w;
    cnt_t sub_w;

    assign add_w  = add_en_i ? add_i : '0;
    assign sub_w  = sub_en_i ? sub_i : '0;
    assign fits_o = ({1'b0, used_q} + {1'b0, add_i}) <= {1'b0, limit_i};
    assign used_o = used_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            used_q <= '0;
        end else begin
            used_q <= used_q + add_w - sub_w;
        end
    end

endmodule

// File: rtl/blk_admit_occ.sv
module blk_admit_occ
    import blk_admit_pkg::*;
#(
    parameter int WARP_LANES = 32,
    parameter int MAX_WARPS  = 64,
    parameter int WW         = 7,
    parameter int OW         = 8
) (
    input  cnt_t          thr_used_i,
    output logic [WW-1:0] warps_o,
    output logic [OW-1:0] occ_o
);

    localparam int LANE_SHIFT = $clog2(WARP_LANES);
    localparam int SW_        = WW + OW;

    logic [SW_-1:0] scaled;

    assign warps_o = WW'(thr_used_i >> LANE_SHIFT);
    assign scaled  = SW_'(warps_o) << (OW - 1);
    assign occ_o   = OW'(scaled / SW_'(MAX_WARPS));

endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl
    import blk_admit_pkg::*;
#(
    parameter int WARP_LANES        = 32,
    parameter int MAX_BLOCKS        = 16,
    parameter int MAX_THREADS       = 2048,
    parameter int REG_FILE          = 65536,
    parameter int MAX_REGS          = 255,
    parameter int MAX_BLOCK_THREADS = 1024,
    parameter int SHMEM_BYTES       = 65536,
    parameter int TW                = 11,
    parameter int RW                = 9,
    parameter int SW                = 17,
    parameter int OW                = 8,
    parameter int MAX_WARPS         = MAX_THREADS / WARP_LANES,
    parameter int WW                = $clog2(MAX_WARPS + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_split_i,
    input  logic          req_valid_i,
    input  logic [TW-1:0] req_threads_i,
    input  logic [RW-1:0] req_regs_i,
    input  logic [SW-1:0] req_shmem_i,
    output logic          req_grant_o,
    output logic          req_error_o,
    input  logic          rel_valid_i,
    input  logic [TW-1:0] rel_threads_i,
    input  logic [RW-1:0] rel_regs_i,
    input  logic [SW-1:0] rel_shmem_i,
    output logic [WW-1:0] warps_o,
    output logic [OW-1:0] occupancy_o
);

    localparam int SPLIT_UNIT = SHMEM_BYTES / 4;

    cost_vec_t            req_cost;
    cost_vec_t            rel_cost;
    cost_vec_t            limit_v;
    cost_vec_t            used_v;
    logic                 req_bad;
    logic                 rel_bad;
    logic                 rel_ok;
    logic [NUM_POOLS-1:0] fits_v;
    logic [1:0]           split_q;
    cnt_t                 shm_limit;
    cnt_t                 blk_used_w;
    cnt_t                 thr_used_w;
    cnt_t                 reg_used_w;
    cnt_t                 shm_used_w;

    blk_admit_cost #(
        .WARP_LANES(WARP_LANES), .MAX_REGS(MAX_REGS),
        .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS), .TW(TW), .RW(RW), .SW(SW)
    ) u_req_cost (
        .threads_i(req_threads_i), .regs_i(req_regs_i), .shmem_i(req_shmem_i),
        .cost_o(req_cost), .bad_o(req_bad)
    );

    blk_admit_cost #(
        .WARP_LANES(WARP_LANES), .MAX_REGS(MAX_REGS),
        .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS), .TW(TW), .RW(RW), .SW(SW)
    ) u_rel_cost (
        .threads_i(rel_threads_i), .regs_i(rel_regs_i), .shmem_i(rel_shmem_i),
        .cost_o(rel_cost), .bad_o(rel_bad)
    );

    // shared-memory split register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            split_q <= 2'd2;
        end else if (cfg_we_i) begin
            split_q <= cfg_split_i;
        end
    end

    always_comb begin
        unique case (split_q)
            2'd0:    shm_limit = CW'(SPLIT_UNIT);
            2'd1:    shm_limit = CW'(2 * SPLIT_UNIT);
            default: shm_limit = CW'(3 * SPLIT_UNIT);
        endcase
    end

    always_comb begin
        limit_v           = '0;
        limit_v[POOL_BLK] = CW'(MAX_BLOCKS);
        limit_v[POOL_THR] = CW'(MAX_THREADS);
        limit_v[POOL_REG] = CW'(REG_FILE);
        limit_v[POOL_SHM] = shm_limit;
    end

    assign req_error_o = req_valid_i && req_bad;
    assign req_grant_o = req_valid_i && !req_bad && (&fits_v);
    assign rel_ok      = rel_valid_i && !rel_bad;

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        blk_admit_pool u_pool (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .limit_i (limit_v[p]),
            .add_en_i(req_grant_o),
            .add_i   (req_cost[p]),
            .sub_en_i(rel_ok),
            .sub_i   (rel_cost[p]),
            .fits_o  (fits_v[p]),
            .used_o  (used_v[p])
        );
    end

    assign blk_used_w = used_v[POOL_BLK];
    assign thr_used_w = used_v[POOL_THR];
    assign reg_used_w = used_v[POOL_REG];
    assign shm_used_w = used_v[POOL_SHM];

    blk_admit_occ #(
        .WARP_LANES(WARP_LANES), .MAX_WARPS(MAX_WARPS), .WW(WW), .OW(OW)
    ) u_occ (
        .thr_used_i(thr_used_w),
        .warps_o   (warps_o),
        .occ_o     (occupancy_o)
    );

endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk
    import blk_admit_pkg::*;
#(
    parameter int MAX_BLOCKS  = 16,
    parameter int MAX_THREADS = 2048,
    parameter int REG_FILE    = 65536,
    parameter int WW          = 7
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          req_valid_i,
    input logic          req_grant_o,
    input logic          req_error_o,
    input logic          rel_valid_i,
    input logic [WW-1:0] warps_o,
    input cnt_t          blk_used,
    input cnt_t          thr_used,
    input cnt_t          reg_used,
    input cnt_t          shm_used,
    input cnt_t          shm_limit
);

    AST_ERR_NEVER_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_error_o |-> !req_grant_o); // R6

    AST_BLOCK_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_used <= CW'(MAX_BLOCKS)); // R2

    AST_THREAD_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_used <= CW'(MAX_THREADS)); // R3

    AST_REG_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_used <= CW'(REG_FILE)); // R4

    AST_SHM_GRANT_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_grant_o |-> shm_used <= shm_limit); // R5

    AST_GRANT_ADDS_WARPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_grant_o && !rel_valid_i) |=> warps_o > $past(warps_o)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_valid_i && !rel_valid_i) |=> $stable(warps_o)); // R8

endmodule

bind blk_admit_ctrl blk_admit_chk #(
    .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS),
    .REG_FILE(REG_FILE), .WW(WW)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_grant_o(req_grant_o),
    .req_error_o(req_error_o),
    .rel_valid_i(rel_valid_i),
    .warps_o    (warps_o),
    .blk_used   (blk_used_w),
    .thr_used   (thr_used_w),
    .reg_used   (reg_used_w),
    .shm_used   (shm_used_w),
    .shm_limit  (shm_limit)
);

// File: tb/blk_admit_ctrl_bench.sv
`timescale 1ns/1ps
module blk_admit_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_split = 2'd0;
    logic        req_valid = 1'b0;
    logic [10:0] req_threads = '0;
    logic [8:0]  req_regs = '0;
    logic [16:0] req_shmem = '0;
    logic        req_grant;
    logic        req_error;
    logic        rel_valid = 1'b0;
    logic [10:0] rel_threads = '0;
    logic [8:0]  rel_regs = '0;
    logic [16:0] rel_shmem = '0;
    logic [6:0]  warps;
    logic [7:0]  occ;

    always #2.5 clk = ~clk;

    blk_admit_ctrl u_blk_admit_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_split_i(cfg_split),
        .req_valid_i(req_valid), .req_threads_i(req_threads),
        .req_regs_i(req_regs), .req_shmem_i(req_shmem),
        .req_grant_o(req_grant), .req_error_o(req_error),
        .rel_valid_i(rel_valid), .rel_threads_i(rel_threads),
        .rel_regs_i(rel_regs), .rel_shmem_i(rel_shmem),
        .warps_o(warps), .occupancy_o(occ)
    );

    typedef struct {
        bit    grant;
        bit    err;
        int    warps;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // reference model state
    int m_blk = 0, m_thr = 0, m_reg = 0, m_shm = 0, m_cap = 49152;

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step(bit rv, int rt, int rr, int rs,
                        bit lv, int lt, int lr, int ls,
                        bit cw, int cs, string tag);
        exp_t e;
        int   w, lw;
        bit   bad, fit;
        @(negedge clk);
        req_valid = rv; req_threads = 11'(rt); req_regs = 9'(rr); req_shmem = 17'(rs);
        rel_valid = lv; rel_threads = 11'(lt); rel_regs = 9'(lr); rel_shmem = 17'(ls);
        cfg_we = cw; cfg_split = 2'(cs);
        w   = (rt + 31) / 32;
        bad = (rt == 0) || (rt > 1024) || (rr > 255);
        fit = (m_blk + 1 <= 16) && (m_thr + w * 32 <= 2048)
           && (m_reg + w * rr * 32 <= 65536) && (m_shm + rs <= m_cap);
        e.err   = rv && bad;
        e.grant = rv && !bad && fit;
        if (e.grant) begin
            m_blk += 1; m_thr += w * 32; m_reg += w * rr * 32; m_shm += rs;
        end
        if (lv) begin
            lw = (lt + 31) / 32;
            m_blk -= 1; m_thr -= lw * 32; m_reg -= lw * lr * 32; m_shm -= ls;
        end
        if (cw) m_cap = (cs == 0) ? 16384 : (cs == 1) ? 32768 : 49152;
        e.warps = m_thr / 32;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic rq(int t, int r, int s, string tag);
        step(1, t, r, s, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic rl(int t, int r, int s, string tag);
        step(0, 0, 0, 0, 1, t, r, s, 0, 0, tag);
    endtask
    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compares design outputs against queued expectations
    initial begin
        exp_t prev;
        bit   have_prev = 0;
        forever begin
            @(negedge clk);
            #1.5;
            if (have_prev) begin
                chk(warps == 7'(prev.warps), {prev.tag, " warps R1"}, warps, prev.warps);
                chk(occ == 8'(prev.warps * 2), {prev.tag, " occupancy R9"}, occ, prev.warps * 2);
                have_prev = 0;
            end
            if (exp_q.size() > 0) begin
                prev = exp_q.pop_front();
                chk(req_grant == prev.grant, {prev.tag, " grant R7"}, req_grant, prev.grant);
                chk(req_error == prev.err, {prev.tag, " error R6"}, req_error, prev.err);
                have_prev = 1;
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(warps == 0, "R10 reset warps", warps, 0);
        chk(occ == 0, "R10 reset occupancy", occ, 0);
        idle("R10");

        rq(161, 16, 0, "R1");
        rl(161, 16, 0, "R8");

        rq(0, 0, 0, "R6");
        rq(1025, 0, 0, "R6");
        rq(32, 256, 0, "R6");

        for (int i = 0; i < 17; i++) rq(32, 0, 0, "R2");
        for (int i = 0; i < 16; i++) rl(32, 0, 0, "R2");

        rq(1024, 0, 0, "R3");
        rq(1024, 0, 0, "R3 R9");
        rq(32, 0, 0, "R3");
        step(1, 32, 0, 0, 1, 1024, 0, 0, 0, 0, "R8 full");
        step(1, 512, 0, 0, 1, 1024, 0, 0, 0, 0, "R8 both");
        rl(512, 0, 0, "R8");

        rq(1024, 64, 0, "R4");
        rq(32, 1, 0, "R4");
        rl(1024, 64, 0, "R4");
        rq(1024, 255, 0, "R4");

        rq(32, 0, 49152, "R5");
        rq(32, 0, 1, "R5");
        rl(32, 0, 49152, "R5");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R5 cfg");
        rq(32, 0, 16385, "R5");
        rq(32, 0, 16384, "R5");
        rl(32, 0, 16384, "R5");
        idle("R8");
        idle("R8");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule